// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Sequencer

This block is the SPI master for an eight-channel, 12-bit successive-approximation converter that talks in 16-bit frames. A client asks for either one channel or a scan over any subset of the eight channels, given as an 8-bit enable mask. The block turns the request into a run of command frames, one per selected channel. It then hands each 12-bit result, labelled with its channel number, to a valid/ready output stream.

The converter answers one frame late: the word it shifts out during a frame belongs to the command of the frame before. The sequencer hides this. It discards the first response of each transaction, adds a trailing all-zero command, and pairs every response with the channel sent one frame earlier. The serial clock comes from the system clock through a parameterised divider. Chip select stays asserted for a whole transaction. When the consumer stalls, the block parks the serial clock between frames.

Top module: `adc_scan_seq`

## Requirements
- R1: The bus runs in SPI mode 3. SCLK is high whenever CS_n is high, MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge. Within a frame, consecutive SCLK rising edges are 2×DIV system clocks apart.
- R2: Each frame is 16 bits, sent MSB first. A command word holds the channel number in bits [13:11], and all of its other bits are zero.
- R3: The result reported is bits [11:0] of the response word. Bits [15:12] are dropped. A value whose two lowest bits are zero, as a 10-bit converter returns, passes through unchanged.
- R4: The response of the first frame of a transaction is never output. Every result carries the channel that was commanded in the frame before it.
- R5: A scan (req_scan=1) sends one command per set bit of req_mask in ascending channel order, then one all-zero command. Its results come out in the same ascending order, one per set bit.
- R6: A single read (req_scan=0) of channel req_chan is exactly two frames: that channel's command, then an all-zero command. It yields exactly one result.
- R7: A scan request with an all-zero mask causes no CS_n activity and no output. It pulses done in the cycle after acceptance, and busy stays low.
- R8: CS_n stays low across all frames of a transaction and is high for at least 2×DIV system clocks between transactions. It is high whenever busy is low.
- R9: While out_valid is high and out_ready is low, out_chan and out_data hold steady and SCLK does not toggle.
- R10: busy rises the cycle after a request is accepted. done is a single-cycle pulse with busy low, given after the last result has been taken. A request presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_scan | input | 1 | 1 = scan by mask, 0 = single-channel read |
| req_chan | input | 3 | Channel for a single read |
| req_mask | input | 8 | Channel-enable mask for a scan, bit n = channel n |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_chan | output | 3 | Channel the result belongs to |
| out_data | output | 12 | Unsigned 12-bit sample |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command out |
| miso | input | 1 | Serial response in |

## Verification
A result appears on out_valid one system clock after the 16th SCLK rising edge of the frame that follows its command. done follows 2×DIV clocks after CS_n rises, once the last result has been taken. The bench does not predict these absolute cycle numbers. It records each handshake on the falling clock edge and each bus word at the slave model's SCLK edges, then compares order and content once done arrives. Only a few results are checked at a fixed offset: busy on the falling edge right after acceptance, and the zero-mask done on the falling edge after its request. SCLK spacing, CS_n gaps and clock stalls are measured continuously in clock cycles and compared with 2×DIV.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_BITS  = 16;
    localparam int NUM_CH      = 8;
    localparam int CH_BITS     = $clog2(NUM_CH);
    localparam int SAMPLE_BITS = 12;
    localparam int CMD_LSB     = 11;

    typedef logic [FRAME_BITS-1:0]  frame_t;
    typedef logic [CH_BITS-1:0]     chan_t;
    typedef logic [NUM_CH-1:0]      mask_t;
    typedef logic [SAMPLE_BITS-1:0] sample_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_XFER,
        ST_END,
        ST_WAIT,
        ST_DRAIN,
        ST_GAP
    } seq_state_t;

    // channel commanded in a frame, and whether it was a real command
    typedef struct packed {
        chan_t chan;
        logic  live;
    } slot_t;

    typedef struct packed {
        chan_t   chan;
        sample_t data;
    } result_t;

    function automatic frame_t make_cmd(input chan_t ch);
        frame_t w;
        w = '0;
        w[CMD_LSB +: CH_BITS] = ch;
        return w;
    endfunction

    function automatic chan_t lowest_chan(input mask_t m);
        chan_t idx;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) idx = chan_t'(i);
        end
        return idx;
    endfunction

    function automatic mask_t chan_bit(input chan_t ch);
        return mask_t'(1) << ch;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
    import adc_scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  frame_t  tx_word,
    input  logic    step,
    input  logic    miso,
    output logic    sclk,
    output logic    mosi,
    output logic    frame_end,
    output sample_t rx_sample
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

    frame_t         tx_sh;
    logic [BCW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh     <= '0;
            bit_cnt   <= '0;
            sclk      <= 1'b1;
            mosi      <= 1'b0;
            rx_sample <= '0;
        end else if (load) begin
            tx_sh   <= tx_word;
            bit_cnt <= '0;
        end else if (step) begin
            if (sclk) begin
                // falling edge: present next command bit
                sclk  <= 1'b0;
                mosi  <= tx_sh[FRAME_BITS-1];
                tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            end else begin
                // rising edge: capture response bit; upper bits fall off
                sclk      <= 1'b1;
                rx_sample <= {rx_sample[SAMPLE_BITS-2:0], miso};
                bit_cnt   <= bit_cnt + 1'b1;
            end
        end
    end

    assign frame_end = step && !sclk && (bit_cnt == LAST_BIT);
endmodule

// File: rtl/adc_chan_walker.sv
module adc_chan_walker
    import adc_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  mask_t init_mask,
    input  logic  pick,
    output logic  has_more,
    output chan_t next_chan
);
    mask_t remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (init) begin
            remaining <= init_mask;
        end else if (pick && has_more) begin
            remaining <= remaining & ~chan_bit(next_chan);
        end
    end

    assign has_more  = |remaining;
    assign next_chan = lowest_chan(remaining);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_scan,
    input  logic [CH_BITS-1:0]     req_chan,
    input  logic [NUM_CH-1:0]      req_mask,
    output logic                   busy,
    output logic                   done,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [CH_BITS-1:0]     out_chan,
    output logic [SAMPLE_BITS-1:0] out_data,
    output logic                   sclk,
    output logic                   cs_n,
    output logic                   mosi,
    input  logic                   miso
);
    seq_state_t state;
    slot_t      cur_slot;
    slot_t      prev_slot;
    result_t    res_q;
    logic       gap_half;

    mask_t   start_mask;
    logic    tick;
    logic    run;
    logic    step;
    logic    load;
    logic    frame_end;
    logic    has_more;
    chan_t   next_chan;
    frame_t  tx_word;
    sample_t rx_sample;
    logic    accept;

    assign start_mask = req_scan ? req_mask : chan_bit(req_chan);
    assign accept     = (state == ST_IDLE) && req_valid;
    assign run        = (state == ST_XFER) || (state == ST_GAP);
    assign step       = tick && (state == ST_XFER);
    assign load       = (state == ST_LOAD);
    assign tx_word    = has_more ? make_cmd(next_chan) : '0;

    adc_tick_gen #(.DIV(DIV)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    adc_chan_walker i_walk (
        .clk       (clk),
        .rst       (rst),
        .init      (accept),
        .init_mask (start_mask),
        .pick      (load),
        .has_more  (has_more),
        .next_chan (next_chan)
    );

    adc_frame_shift i_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .tx_word   (tx_word),
        .step      (step),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .frame_end (frame_end),
        .rx_sample (rx_sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            out_valid <= 1'b0;
            res_q     <= '0;
            cur_slot  <= '0;
            prev_slot <= '0;
            gap_half  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (start_mask == '0) begin
                            done <= 1'b1;
                        end else begin
                            cs_n      <= 1'b0;
                            prev_slot <= '0;
                            state     <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    cur_slot <= '{chan: next_chan, live: has_more};
                    state    <= ST_XFER;
                end
                ST_XFER: begin
                    if (frame_end) state <= ST_END;
                end
                ST_END: begin
                    // response of this frame belongs to the previous command
                    if (prev_slot.live) begin
                        out_valid <= 1'b1;
                        res_q     <= '{chan: prev_slot.chan, data: rx_sample};
                    end
                    prev_slot <= cur_slot;
                    state     <= cur_slot.live ? ST_WAIT : ST_DRAIN;
                end
                ST_WAIT: begin
                    if (!out_valid) state <= ST_LOAD;
                end
                ST_DRAIN: begin
                    if (!out_valid) begin
                        cs_n     <= 1'b1;
                        gap_half <= 1'b0;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign out_chan = res_q.chan;
    assign out_data = res_q.data;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   busy,
    input logic                   done,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [CH_BITS-1:0]     out_chan,
    input logic [SAMPLE_BITS-1:0] out_data,
    input logic                   sclk,
    input logic                   cs_n,
    input logic                   mosi
);
    a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    a_r1_mosi_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> !sclk);

    a_r8_cs_high_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data)));

    a_r9_sclk_parked: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(sclk));

    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind adc_scan_seq adc_scan_chk i_chk (.*);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;
    localparam int NV = 8;
    // [12]=scan [11:9]=chan [8:1]=mask [0]=ten-bit style data
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 1'b0},
        {1'b0, 3'd7, 8'h00, 1'b1},
        {1'b0, 3'd4, 8'h00, 1'b0},
        {1'b1, 3'd0, 8'hFF, 1'b0},
        {1'b1, 3'd0, 8'h81, 1'b1},
        {1'b1, 3'd0, 8'h5A, 1'b0},
        {1'b1, 3'd0, 8'h01, 1'b0},
        {1'b1, 3'd0, 8'h80, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_scan = 1'b0, out_ready = 1'b1, miso = 1'b1;
    logic [2:0] req_chan = '0;
    logic [7:0] req_mask = '0;
    logic busy, done, out_valid, sclk, cs_n, mosi;
    logic [2:0] out_chan;
    logic [11:0] out_data;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    logic stall_en = 1'b0;

    logic [15:0] resp [8];
    logic [15:0] cmd_log [32];
    int cmd_n = 0;
    logic [2:0] res_ch [32];
    logic [11:0] res_d [32];
    int res_n = 0;

    logic [15:0] s_in, s_out;
    int s_bit = 0;

    int last_rise = -1, min_rise = 1000000;
    int cs_hi = 0, min_cs_gap = 1000000, cs_falls = 0, stall_err = 0;
    logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_stall = 1'b0;
    bit seen_fall = 0;

    adc_scan_seq #(.DIV(DIV)) i_adc_scan_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_scan(req_scan),
        .req_chan(req_chan), .req_mask(req_mask), .busy(busy), .done(done),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
        .out_data(out_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= !stall_en || (cyc % 5 == 0);
    end

    // converter model: answers one frame late, junk upper nibble
    always @(negedge cs_n) begin
        s_bit = 0;
        s_out = 16'hFFFF;
    end
    always @(negedge sclk) if (cs_n === 1'b0) begin
        miso = s_out[15];
        s_out = {s_out[14:0], 1'b0};
    end
    always @(posedge sclk) if (cs_n === 1'b0) begin
        s_in = {s_in[14:0], mosi};
        s_bit++;
        if (s_bit == 16) begin
            cmd_log[cmd_n] = s_in;
            if (cmd_n < 31) cmd_n++;
            s_out = resp[s_in[13:11]];
            s_bit = 0;
        end
    end

    // monitors sampled on falling clock edge
    always @(negedge clk) if (!rst) begin
        if (out_valid && out_ready) begin
            res_ch[res_n] = out_chan;
            res_d[res_n] = out_data;
            if (res_n < 31) res_n++;
        end
        if (sclk && !prev_sclk) begin
            if (last_rise >= 0 && cyc - last_rise < min_rise) min_rise = cyc - last_rise;
            last_rise = cyc;
        end
        if (cs_n) cs_hi++;
        else if (prev_cs) begin
            if (seen_fall && cs_hi < min_cs_gap) min_cs_gap = cs_hi;
            seen_fall = 1;
            cs_falls++;
            cs_hi = 0;
            last_rise = -1;
        end
        if (prev_stall && out_valid && !out_ready && sclk !== prev_sclk) stall_err++;
        prev_stall = out_valid && !out_ready;
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_resp(input int t, input bit ten);
        for (int ch = 0; ch < 8; ch++) begin
            logic [11:0] d;
            d = 12'((ch * 499 + t * 167) ^ 12'h5A5);
            if (ten) d[1:0] = 2'b00;
            resp[ch] = {4'(8 + ch), d};
        end
    endtask

    task automatic issue(input bit scan, input logic [2:0] ch, input logic [7:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_scan = scan; req_chan = ch; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk(0, "R10 done timeout", n, 0);
    endtask

    task automatic check_txn(input logic [7:0] m, input string tag);
        int k;
        k = 0;
        chk(cmd_n == $countones(m) + 1, {tag, " frame count"}, cmd_n, $countones(m) + 1);
        chk(res_n == $countones(m), {tag, " result count"}, res_n, $countones(m));
        for (int ch = 0; ch < 8; ch++) begin
            if (m[ch]) begin
                chk(cmd_log[k] == {2'b00, 3'(ch), 11'b0}, {tag, " R2 command word"},
                    int'(cmd_log[k]), int'({2'b00, 3'(ch), 11'b0}));
                chk(res_ch[k] == 3'(ch), {tag, " R4 result channel"}, int'(res_ch[k]), ch);
                chk(res_d[k] == resp[ch][11:0], {tag, " R3 result data"},
                    int'(res_d[k]), int'(resp[ch][11:0]));
                k++;
            end
        end
        chk(cmd_log[k] == 16'h0000, {tag, " R5 trailing zero command"}, int'(cmd_log[k]), 0);
    endtask

    initial begin
        int falls0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R8 reset cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] m;
            m = VEC[v][12] ? VEC[v][8:1] : (8'h01 << VEC[v][11:9]);
            set_resp(v, VEC[v][0]);
            cmd_n = 0; res_n = 0;
            issue(VEC[v][12], VEC[v][11:9], VEC[v][8:1]);
            chk(busy == 1'b1, "R10 busy after accept", busy, 1);
            wait_done();
            check_txn(m, VEC[v][12] ? "R5 scan" : "R6 single");
        end

        // R7: empty scan
        cmd_n = 0; res_n = 0;
        falls0 = cs_falls;
        @(negedge clk);
        req_valid = 1'b1; req_scan = 1'b1; req_mask = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R7 done next cycle", done, 1);
        chk(busy == 1'b0, "R7 busy stays low", busy, 0);
        repeat (50) @(negedge clk);
        chk(cs_falls == falls0, "R7 no cs activity", cs_falls, falls0);
        chk(res_n == 0, "R7 no output", res_n, 0);

        // R9: stalled consumer
        stall_en = 1'b1;
        set_resp(11, 1'b0);
        cmd_n = 0; res_n = 0;
        issue(1'b1, 3'd0, 8'hFF);
        wait_done();
        check_txn(8'hFF, "R9 stalled scan");
        chk(stall_err == 0, "R9 sclk parked during stall", stall_err, 0);
        stall_en = 1'b0;

        // R10: request while busy is ignored
        set_resp(12, 1'b0);
        cmd_n = 0; res_n = 0;
        issue(1'b1, 3'd0, 8'h04);
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_scan = 1'b1; req_mask = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        falls0 = cs_falls;
        repeat (200) @(negedge clk);
        check_txn(8'h04, "R10 busy request ignored");
        chk(cs_falls == falls0, "R10 no extra transaction", cs_falls, falls0);

        // R8: back-to-back transactions
        cmd_n = 0; res_n = 0;
        issue(1'b0, 3'd3, 8'h00);
        wait_done();
        cmd_n = 0; res_n = 0;
        req_valid = 1'b1; req_scan = 1'b0; req_chan = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        check_txn(8'h20, "R6 back-to-back");
        chk(min_cs_gap >= 2 * DIV, "R8 cs high gap", min_cs_gap, 2 * DIV);
        chk(min_rise == 2 * DIV, "R1 sclk period", min_rise, 2 * DIV);

        finish_run();
    end
endmodule